// File: doc/BRIEF.md
# Programmable Memory Pattern Scrubber

This block is a built-in test engine for a memory that sits behind a simple request/response port. Software loads an address window, a set of eight 64-bit data patterns or a 64-bit LFSR seed, and an operating mode. A start pulse then sends the engine across the window, lowest address first. Depending on the mode it writes every word, reads every word, or writes the whole window and then reads it back. Each returned word is compared with the value that should be there. Mismatches are recorded as one sticky bit per pattern slot, as a running count, and as the address of the first failing word.

The register file of the surrounding controller is modelled as plain ports. A busy flag covers the whole operation. A done flag stays set until a separate clear pulse removes it. Two options change the read side: one halts the run on its first mismatch, and the other still issues the reads but skips the comparison. Every request waits for the memory's ready signal, and the engine keeps at most one read outstanding.

Top module: `mem_pattern_scrubber`

## Requirements
- R1: A `start` pulse while idle launches an operation, and `busy` is high from the following cycle. A start is ignored while busy, when `mode` is 3, or when `range_hi` is below `range_lo`.
- R2: The `mode` encoding is 0 for read only, 1 for write only and 2 for a full write pass followed by a full read pass. Each pass issues exactly one request per word from `range_lo` up to `range_hi` inclusive, in ascending order.
- R3: With `use_lfsr` low, word k of a pass uses pattern slot k mod 8. Slot i is `pat_words[64*i+63:64*i]`.
- R4: With `use_lfsr` high, word k uses an LFSR value. Word 0 gets `lfsr_seed`, and the LFSR advances once per beat with next = {s[62:0], s[63]^s[62]^s[60]^s[59]} (x^64+x^63+x^61+x^60+1). The read pass of mode 2 restarts from the same seed.
- R5: A read response that differs from the expected word sets `err_vec` bit (k mod 8) and increments `err_cnt`. On the first mismatch it captures the word address: bits 31:0 go to `fail_addr_lo` and the upper address bits, zero-extended, go to `fail_addr_hi`.
- R6: With `skip_check` set, every read is still issued, but no response changes the error vector, counter or address.
- R7: With `halt_on_err` set, the operation ends on the response of the first mismatching read, and no further request is issued.
- R8: `done` rises in the same cycle that `busy` falls and holds until a `done_clr` pulse clears it one cycle later. Completion wins over a simultaneous clear, and a start does not clear it.
- R9: An accepted start clears `err_vec`, `err_cnt` and the captured address.
- R10: A request is held with stable address and direction until `mem_req_ready`. After a read is accepted, no request is issued until its response arrives. No request is issued while idle.
- R11: After reset, `busy`, `done`, `err_vec`, `err_cnt`, the captured address and `mem_req_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle enable pulse |
| mode | input | 2 | 0 read, 1 write, 2 write then read, 3 reserved |
| halt_on_err | input | 1 | End the run on the first mismatch |
| skip_check | input | 1 | Issue reads without comparing |
| use_lfsr | input | 1 | Take data from the LFSR instead of the patterns |
| lfsr_seed | input | 64 | LFSR starting value |
| pat_words | input | 512 | Eight 64-bit pattern slots, slot 0 in the low bits |
| range_lo | input | 40 | First word address |
| range_hi | input | 40 | Last word address (inclusive) |
| done_clr | input | 1 | Write-1 pulse that clears `done` |
| mem_req_valid | output | 1 | Request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | 40 | Word address |
| mem_req_wdata | output | 64 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 64 | Read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Sticky completion flag |
| err_vec | output | 8 | Per-slot mismatch bits |
| err_cnt | output | 32 | Mismatch count |
| fail_addr_lo | output | 32 | First mismatch address, bits 31:0 |
| fail_addr_hi | output | 32 | First mismatch address, upper bits |

## Verification
The hardest case to reach is a mismatch on the read pass of a write-then-read run. It has to occur on a word whose slot index wraps past eight, while the memory stalls and the halt or skip options change what should follow. From the ports, a mismatch can only come from the memory returning data that differs from what was just written. The bench memory therefore carries a per-address fault mask that it XORs onto read data only. Tests run ranges longer than eight words under random ready stalls and random response latency, and place faults on chosen word indices, including an address window with nonzero upper bits.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
    localparam int WORD_W = 64;

    localparam logic [1:0] MODE_RD   = 2'd0;
    localparam logic [1:0] MODE_WR   = 2'd1;
    localparam logic [1:0] MODE_WRRD = 2'd2;
    localparam logic [1:0] MODE_RSVD = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_RDREQ = 2'd2,
        ST_RDWT  = 2'd3
    } scrub_state_e;

    // x^64 + x^63 + x^61 + x^60 + 1, shift toward the MSB
    function automatic logic [WORD_W-1:0] lfsr_next(input logic [WORD_W-1:0] s);
        return {s[WORD_W-2:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
    endfunction
endpackage

// File: rtl/scrub_lfsr.sv
module scrub_lfsr
    import scrub_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] seed,
    input  logic              step,
    output logic [WORD_W-1:0] value
);
    typedef struct packed {
        logic [WORD_W-1:0] s;
    } lfsr_t;

    lfsr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.s = seed;
        end else if (step) begin
            st_d.s = lfsr_next(st_q.s);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value = st_q.s;
endmodule

// File: rtl/scrub_errlog.sv
module scrub_errlog #(
    parameter int ADDR_W = 40,
    parameter int SLOTS  = 8,
    parameter int CNT_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     hit,
    input  logic [$clog2(SLOTS)-1:0] slot,
    input  logic [ADDR_W-1:0]        addr,
    output logic [SLOTS-1:0]         vec,
    output logic [CNT_W-1:0]         cnt,
    output logic [31:0]              addr_lo,
    output logic [31:0]              addr_hi
);
    typedef struct packed {
        logic [SLOTS-1:0]  vec;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] first;
    } log_t;

    log_t lg_d, lg_q;
    logic [63:0] first_wide;

    always_comb begin
        lg_d = lg_q;
        if (clr) begin
            lg_d = '0;
        end else if (hit) begin
            lg_d.vec[slot] = 1'b1;
            if (lg_q.cnt == '0) lg_d.first = addr;
            if (lg_q.cnt != '1) lg_d.cnt = lg_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lg_q <= '0;
        else        lg_q <= lg_d;
    end

    assign first_wide = 64'(lg_q.first);
    assign vec        = lg_q.vec;
    assign cnt        = lg_q.cnt;
    assign addr_lo    = first_wide[31:0];
    assign addr_hi    = first_wide[63:32];

    AST_CNT_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> lg_q.cnt >= $past(lg_q.cnt)); // R5
    AST_VEC_NEEDS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (lg_q.cnt == '0) |-> (lg_q.vec == '0)); // R5
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (lg_q.cnt == '0) && (lg_q.first == '0)); // R9
endmodule

// File: rtl/mem_pattern_scrubber.sv
module mem_pattern_scrubber
    import scrub_pkg::*;
#(
    parameter int ADDR_W  = 40,
    parameter int NUM_PAT = 8,   // power of two: the slot counter wraps by itself
    parameter int CNT_W   = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [1:0]                mode,
    input  logic                      halt_on_err,
    input  logic                      skip_check,
    input  logic                      use_lfsr,
    input  logic [WORD_W-1:0]         lfsr_seed,
    input  logic [NUM_PAT*WORD_W-1:0] pat_words,
    input  logic [ADDR_W-1:0]         range_lo,
    input  logic [ADDR_W-1:0]         range_hi,
    input  logic                      done_clr,
    output logic                      mem_req_valid,
    input  logic                      mem_req_ready,
    output logic                      mem_req_write,
    output logic [ADDR_W-1:0]         mem_req_addr,
    output logic [WORD_W-1:0]         mem_req_wdata,
    input  logic                      mem_rsp_valid,
    input  logic [WORD_W-1:0]         mem_rsp_rdata,
    output logic                      busy,
    output logic                      done,
    output logic [NUM_PAT-1:0]        err_vec,
    output logic [CNT_W-1:0]          err_cnt,
    output logic [31:0]               fail_addr_lo,
    output logic [31:0]               fail_addr_hi
);
    localparam int SLOT_W = $clog2(NUM_PAT);

    typedef struct packed {
        scrub_state_e      st;
        logic [1:0]        mode;
        logic              halt;
        logic              skip;
        logic              rnd;
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
        logic [ADDR_W-1:0] cur;
        logic [SLOT_W-1:0] slot;
        logic [WORD_W-1:0] seed;
        logic              done;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [WORD_W-1:0] pat_arr [NUM_PAT];
    logic [WORD_W-1:0] lfsr_val, lfsr_ld_val, data_sel;
    logic              lfsr_ld, lfsr_step, log_clr, log_hit, is_last, finish;

    for (genvar g = 0; g < NUM_PAT; g++) begin : g_pat
        assign pat_arr[g] = pat_words[g*WORD_W +: WORD_W];
    end

    assign data_sel = c_q.rnd ? lfsr_val : pat_arr[c_q.slot];
    assign is_last  = (c_q.cur == c_q.hi);

    always_comb begin
        c_d         = c_q;
        lfsr_ld     = 1'b0;
        lfsr_ld_val = c_q.seed;
        lfsr_step   = 1'b0;
        log_clr     = 1'b0;
        log_hit     = 1'b0;
        finish      = 1'b0;

        unique case (c_q.st)
            ST_IDLE: begin
                if (start && (mode != MODE_RSVD) && (range_lo <= range_hi)) begin
                    c_d.mode    = mode;
                    c_d.halt    = halt_on_err;
                    c_d.skip    = skip_check;
                    c_d.rnd     = use_lfsr;
                    c_d.lo      = range_lo;
                    c_d.hi      = range_hi;
                    c_d.cur     = range_lo;
                    c_d.slot    = '0;
                    c_d.seed    = lfsr_seed;
                    c_d.st      = (mode == MODE_RD) ? ST_RDREQ : ST_WRITE;
                    lfsr_ld     = 1'b1;
                    lfsr_ld_val = lfsr_seed;
                    log_clr     = 1'b1;
                end
            end
            ST_WRITE: begin
                if (mem_req_ready) begin
                    lfsr_step = 1'b1;
                    if (!is_last) begin
                        c_d.cur  = c_q.cur + ADDR_W'(1);
                        c_d.slot = c_q.slot + SLOT_W'(1);
                    end else if (c_q.mode == MODE_WRRD) begin
                        c_d.st   = ST_RDREQ;
                        c_d.cur  = c_q.lo;
                        c_d.slot = '0;
                        lfsr_ld  = 1'b1;
                    end else begin
                        finish = 1'b1;
                    end
                end
            end
            ST_RDREQ: begin
                if (mem_req_ready) c_d.st = ST_RDWT;
            end
            ST_RDWT: begin
                if (mem_rsp_valid) begin
                    lfsr_step = 1'b1;
                    log_hit   = !c_q.skip && (mem_rsp_rdata != data_sel);
                    if ((log_hit && c_q.halt) || is_last) begin
                        finish = 1'b1;
                    end else begin
                        c_d.st   = ST_RDREQ;
                        c_d.cur  = c_q.cur + ADDR_W'(1);
                        c_d.slot = c_q.slot + SLOT_W'(1);
                    end
                end
            end
            default: c_d.st = ST_IDLE;
        endcase

        if (finish) begin
            c_d.st   = ST_IDLE;
            c_d.done = 1'b1;
        end else if (done_clr) begin
            c_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    scrub_lfsr u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (lfsr_ld),
        .seed  (lfsr_ld_val),
        .step  (lfsr_step),
        .value (lfsr_val)
    );

    scrub_errlog #(
        .ADDR_W (ADDR_W),
        .SLOTS  (NUM_PAT),
        .CNT_W  (CNT_W)
    ) u_log (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (log_clr),
        .hit     (log_hit),
        .slot    (c_q.slot),
        .addr    (c_q.cur),
        .vec     (err_vec),
        .cnt     (err_cnt),
        .addr_lo (fail_addr_lo),
        .addr_hi (fail_addr_hi)
    );

    assign mem_req_valid = (c_q.st == ST_WRITE) || (c_q.st == ST_RDREQ);
    assign mem_req_write = (c_q.st == ST_WRITE);
    assign mem_req_addr  = c_q.cur;
    assign mem_req_wdata = data_sel;
    assign busy          = (c_q.st != ST_IDLE);
    assign done          = c_q.done;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)); // R10
    AST_ONE_READ_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready && !mem_req_write |=> !mem_req_valid); // R10
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid); // R10
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R8
    AST_SKIP_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        busy && c_q.skip |=> $stable(err_cnt) && $stable(err_vec)); // R6
    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr >= c_q.lo) && (mem_req_addr <= c_q.hi)); // R2
    AST_NO_RESERVED_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> c_q.mode != MODE_RSVD); // R1
endmodule

// File: tb/tb_mem_pattern_scrubber.sv
`timescale 1ns/1ps
module tb_mem_pattern_scrubber;
    localparam int AW = 40;
    localparam int DW = 64;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic          halt_on_err = 1'b0;
    logic          skip_check = 1'b0;
    logic          use_lfsr = 1'b0;
    logic [DW-1:0] lfsr_seed = '0;
    logic [NP*DW-1:0] pat_words = '0;
    logic [AW-1:0] range_lo = '0;
    logic [AW-1:0] range_hi = '0;
    logic          done_clr = 1'b0;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b0;
    logic          mem_req_write;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata;
    logic          mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_rdata = '0;
    logic          busy, done;
    logic [NP-1:0] err_vec;
    logic [31:0]   err_cnt, fail_addr_lo, fail_addr_hi;

    always #2 clk = ~clk;

    mem_pattern_scrubber dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .halt_on_err(halt_on_err), .skip_check(skip_check), .use_lfsr(use_lfsr),
        .lfsr_seed(lfsr_seed), .pat_words(pat_words), .range_lo(range_lo),
        .range_hi(range_hi), .done_clr(done_clr), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .busy(busy), .done(done), .err_vec(err_vec), .err_cnt(err_cnt),
        .fail_addr_lo(fail_addr_lo), .fail_addr_hi(fail_addr_hi)
    );

    typedef struct {
        bit            wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        int            k;
        bit            last;
    } op_t;

    int n_chk = 0;
    int n_err = 0;
    op_t exp_q[$];
    op_t rd_item;
    logic [DW-1:0] mem   [32];
    logic [DW-1:0] fault [32];
    bit  m_busy = 0, m_done = 0, m_skip = 0, m_halt = 0;
    logic [NP-1:0] m_vec = '0;
    int unsigned   m_cnt = 0;
    logic [AW-1:0] m_first = '0;
    bit  rd_pending = 0;
    int  rd_delay = 0;
    int  rd_issued = 0;
    bit  stall_en = 0;
    bit  req_start = 0, req_clr = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] lfsr_adv(input logic [DW-1:0] s);
        return {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
    endfunction

    task automatic build_ops();
        int unsigned words;
        logic [DW-1:0] x;
        words = int'(range_hi - range_lo) + 1;
        exp_q.delete();
        for (int pass = 0; pass < 2; pass++) begin
            bit is_wr;
            is_wr = (pass == 0);
            if (is_wr && mode == 2'd0) continue;
            if (!is_wr && mode == 2'd1) continue;
            x = lfsr_seed;
            for (int k = 0; k < int'(words); k++) begin
                op_t o;
                o.wr   = is_wr;
                o.addr = range_lo + AW'(k);
                o.data = use_lfsr ? x : pat_words[(k % NP)*DW +: DW];
                o.k    = k;
                o.last = (k == int'(words) - 1) && !(is_wr && mode == 2'd2);
                exp_q.push_back(o);
                x = lfsr_adv(x);
            end
        end
    endtask

    // one clock of checking, memory behaviour and reference model
    task automatic step();
        bit fin, start_now, mis;
        @(negedge clk);
        chk(busy == m_busy, "R8 busy", 64'(busy), 64'(m_busy));
        chk(done == m_done, "R8 done", 64'(done), 64'(m_done));
        chk(err_vec == m_vec, "R5 err_vec", 64'(err_vec), 64'(m_vec));
        chk(err_cnt == m_cnt, "R5 err_cnt", 64'(err_cnt), 64'(m_cnt));
        chk({fail_addr_hi, fail_addr_lo} == 64'(m_first), "R5 fail_addr",
            {fail_addr_hi, fail_addr_lo}, 64'(m_first));
        if (mem_req_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 request without pending work", 64'(mem_req_addr), 64'(0));
            end else begin
                chk(mem_req_write == exp_q[0].wr, "R2 direction", 64'(mem_req_write), 64'(exp_q[0].wr));
                chk(mem_req_addr == exp_q[0].addr, "R2 address", 64'(mem_req_addr), 64'(exp_q[0].addr));
                if (exp_q[0].wr)
                    chk(mem_req_wdata == exp_q[0].data, "R3/R4 write data", mem_req_wdata, exp_q[0].data);
            end
            chk(!rd_pending, "R10 request during outstanding read", 64'(rd_pending), 64'(0));
        end
        start         = req_start;
        done_clr      = req_clr;
        mem_req_ready = stall_en ? ($urandom % 3 != 0) : 1'b1;
        mem_rsp_valid = 1'b0;
        fin = 0;
        start_now = req_start && !m_busy && (mode != 2'd3) && (range_lo <= range_hi);
        if (rd_pending) begin
            rd_delay--;
            if (rd_delay == 0) begin
                rd_pending    = 0;
                mem_rsp_valid = 1'b1;
                mem_rsp_rdata = mem[rd_item.addr[4:0]] ^ fault[rd_item.addr[4:0]];
                mis = !m_skip && (mem_rsp_rdata != rd_item.data);
                if (mis) begin
                    m_vec[rd_item.k % NP] = 1'b1;
                    if (m_cnt == 0) m_first = rd_item.addr;
                    m_cnt++;
                end
                if ((mis && m_halt) || rd_item.last) fin = 1;
            end
        end
        if (mem_req_valid && mem_req_ready && exp_q.size() > 0) begin
            op_t o;
            o = exp_q.pop_front();
            if (o.wr) begin
                mem[o.addr[4:0]] = o.data;
                if (o.last) fin = 1;
            end else begin
                rd_pending = 1;
                rd_delay   = 1 + int'($urandom % 3);
                rd_item    = o;
                rd_issued++;
            end
        end
        if (fin) begin
            m_busy = 0;
            m_done = 1;
            exp_q.delete();
        end else if (req_clr) begin
            m_done = 0;
        end
        if (start_now) begin
            m_busy  = 1;
            m_skip  = skip_check;
            m_halt  = halt_on_err;
            m_vec   = '0;
            m_cnt   = 0;
            m_first = '0;
            build_ops();
        end
        req_start = 0;
        req_clr   = 0;
    endtask

    task automatic run_op(input logic [1:0] md, input logic [AW-1:0] lo, input logic [AW-1:0] hi,
                          input bit rnd, input bit halt, input bit skip);
        int guard;
        mode = md; range_lo = lo; range_hi = hi;
        use_lfsr = rnd; halt_on_err = halt; skip_check = skip;
        rd_issued = 0;
        req_start = 1;
        step();
        guard = 0;
        while (m_busy && guard < 5000) begin
            step();
            guard++;
        end
        step();
    endtask

    task automatic clear_faults();
        for (int i = 0; i < 32; i++) fault[i] = '0;
    endtask

    initial begin
        #(200000 * 4);
        n_err++;
        $display("FAIL R1 watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) mem[i] = '0;
        clear_faults();
        for (int i = 0; i < NP; i++)
            pat_words[i*DW +: DW] = {32'hA5C3_0000 + 32'(i), 32'h1234_5678 ^ (32'(i) << 8)};
        lfsr_seed = 64'hDEAD_BEEF_0BAD_F00D;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(!busy && !done && !mem_req_valid, "R11 idle after reset", {busy, done, mem_req_valid}, 0);
        chk(err_cnt == 0 && err_vec == 0, "R11 errors after reset", {err_vec, err_cnt}, 0);
        chk(fail_addr_lo == 0 && fail_addr_hi == 0, "R11 addr after reset", {fail_addr_hi, fail_addr_lo}, 0);

        // R2/R3: write-only with patterns, 10 words so slots wrap
        stall_en = 1;
        run_op(2'd1, 40'd0, 40'd9, 0, 0, 0);
        chk(done == 1'b1, "R8 done after write pass", 64'(done), 1);
        chk(mem[9] == pat_words[1*DW +: DW], "R3 slot wrap stored", mem[9], pat_words[1*DW +: DW]);
        req_clr = 1; step(); step();
        chk(done == 1'b0, "R8 done cleared by clear pulse", 64'(done), 0);

        // R2/R5: read-only, fault on word 9 (slot 1)
        fault[9] = 64'h0000_0100_0000_0000;
        run_op(2'd0, 40'd0, 40'd9, 0, 0, 0);
        chk(err_cnt == 1 && err_vec == 8'h02, "R5 read-only single mismatch", {err_vec, err_cnt}, {8'h02, 32'd1});
        chk(fail_addr_lo == 9, "R5 first address", 64'(fail_addr_lo), 9);
        clear_faults();

        // R4/R9: write then read with LFSR, faults on words 4 and 9
        fault[4] = 64'h1; fault[9] = 64'h8000_0000_0000_0000;
        run_op(2'd2, 40'd0, 40'd11, 1, 0, 0);
        chk(err_cnt == 2 && err_vec == 8'h12, "R4 LFSR read-back mismatches", {err_vec, err_cnt}, {8'h12, 32'd2});
        chk(fail_addr_lo == 4, "R9 first address replaced on restart", 64'(fail_addr_lo), 4);
        clear_faults();

        // R7: halt on first mismatch, faults on words 2 and 5
        fault[2] = 64'hF0; fault[5] = 64'hF00;
        run_op(2'd2, 40'd0, 40'd9, 0, 1, 0);
        chk(err_cnt == 1 && err_vec == 8'h04, "R7 halt counts one", {err_vec, err_cnt}, {8'h04, 32'd1});
        chk(rd_issued == 3, "R7 no reads after halt", 64'(rd_issued), 3);

        // R6: compare bypass with the same faults
        run_op(2'd0, 40'd0, 40'd9, 0, 0, 1);
        chk(err_cnt == 0 && err_vec == 0, "R6 bypass records nothing", {err_vec, err_cnt}, 0);
        chk(rd_issued == 10, "R6 all reads issued", 64'(rd_issued), 10);
        clear_faults();

        // R1: reserved mode and inverted range are ignored
        req_clr = 1; step();
        run_op(2'd3, 40'd0, 40'd5, 0, 0, 0);
        chk(!busy && !done, "R1 reserved mode ignored", {busy, done}, 0);
        run_op(2'd1, 40'd7, 40'd3, 0, 0, 0);
        chk(!busy && !done, "R1 inverted range ignored", {busy, done}, 0);

        // R1: start while busy is ignored (model keeps the first operation)
        mode = 2'd1; range_lo = 40'd0; range_hi = 40'd15; use_lfsr = 1;
        halt_on_err = 0; skip_check = 0;
        req_start = 1; step();
        step(); step();
        mode = 2'd0; range_hi = 40'd3; req_start = 1; step();
        begin
            int g = 0;
            while (m_busy && g < 2000) begin step(); g++; end
        end
        step();
        chk(done == 1'b1 && !busy, "R1 first operation completes", {busy, done}, 1);

        // R5: upper address half, fault at word index 2
        fault[6] = 64'h55;
        run_op(2'd2, 40'h12_0000_0004, 40'h12_0000_000A, 0, 0, 0);
        chk(fail_addr_hi == 32'h12 && fail_addr_lo == 32'h6, "R5 upper half captured",
            {fail_addr_hi, fail_addr_lo}, {32'h12, 32'h6});
        chk(err_vec == 8'h04, "R5 slot of upper-range word", 64'(err_vec), 4);
        clear_faults();

        // R9: clean restart clears the log
        stall_en = 0;
        run_op(2'd0, 40'h12_0000_0004, 40'h12_0000_000A, 0, 0, 0);
        chk(err_cnt == 0 && fail_addr_hi == 0 && fail_addr_lo == 0, "R9 start clears log",
            {err_cnt, fail_addr_lo}, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule